// File: doc/BRIEF.md
# Peripheral Supply Calibration Controller

This block picks the supply step for the peripheral logic of a memory device. A calibration starts on one of two events: the end of power-up or the exit from self-refresh. The block sends a one-cycle launch pulse into an external replica path, which copies the delay from the clock input to the data output. It then counts the input-clock cycles until the replica return arrives. The return passes through a two-flop synchroniser, and that latency is taken out of the count. The count depends on two things: how fast the silicon is and how fast the applied clock is.

The block compares the count with a programmable window. A count above the upper bound means the silicon is too slow for this clock, so the block sends a one-cycle raise request to the regulator. A count below the lower bound means there is spare margin, so it sends a one-cycle lower request. After each request the block waits a programmable settle time and then measures again. The loop ends in one of three ways:
- the count falls inside the window;
- the step index reaches its clamp in the needed direction;
- the number of adjust rounds reaches its cap.

At the end the chosen step is held until the next event. No other supply is ever requested to change.

Top module: `periph_dvs_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, step_idx equals STEP_INIT. On those cycles busy, done, launch, raise, lower, the limit flag and the timeout flag are all low.
- R2: In idle, a high level on either event input at a clock edge starts a calibration. In the cycle that follows, launch is high and busy is high. Busy stays high until the done pulse.
- R3: The reported count equals min(D, 2^CNT_W-1). D is the number of clock edges from the edge that first samples launch high to the first edge that samples the replica return high. If no return arrives, the count saturates at 2^CNT_W-1.
- R4: If the count is greater than win_hi, the block gives a one-cycle raise pulse, and step_idx rises by one in that same cycle.
- R5: If the count is less than win_lo, the block gives a one-cycle lower pulse, and step_idx falls by one in that same cycle.
- R6: If the count is in the range win_lo to win_hi (both bounds included), the calibration ends with no step request, and step_idx keeps its value.
- R7: Raise and lower are never high together. Launch is never high for two cycles in a row.
- R8: After a step pulse, the next launch pulse comes exactly settle_len+1 cycles after the step pulse.
- R9: If the count calls for a step beyond STEP_MAX (raise) or STEP_MIN (lower), no pulse is issued, the limit flag is set and the calibration ends. step_idx always stays within STEP_MIN to STEP_MAX.
- R10: If MAX_ITER steps have already been made and the count is still outside the window, no pulse is issued, the timeout flag is set, the calibration ends and step_idx is kept. The timeout check takes priority over the limit check.
- R11: The end of a calibration is marked by a one-cycle done pulse. Busy is low in the next cycle. The limit and timeout flags keep their values until the edge that starts the next calibration, which clears them.
- R12: Outside a calibration, step_idx does not change. An event that arrives while busy is high is ignored and does not cause a second calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the delay is measured in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| pwrup_evt | input | 1 | Power-up complete event |
| srexit_evt | input | 1 | Self-refresh exit event |
| win_hi | input | CNT_W | Upper bound of the target count window |
| win_lo | input | CNT_W | Lower bound of the target count window |
| settle_len | input | SETTLE_W | Settle time, in cycles, after each step request |
| replica_ret | input | 1 | Asynchronous return from the replica path |
| replica_launch | output | 1 | One-cycle pulse into the replica path |
| vreg_up | output | 1 | Raise request to the regulator |
| vreg_dn | output | 1 | Lower request to the regulator |
| step_idx | output | STEP_W | Current supply step index |
| meas_count | output | CNT_W | Last measured count |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle end-of-calibration pulse |
| at_limit | output | 1 | Last calibration stopped at the step clamp |
| cal_timeout | output | 1 | Last calibration ran out of rounds |

## Verification
The bench builds the block with these parameters:

| Parameter | Value |
|---|---|
| CNT_W | 6 (saturation at 63) |
| STEP range | 0 to 7, starting at 3 |
| MAX_ITER | 3 |
| SETTLE_W | 4 |

With these values every outcome occurs within a few short calibrations: window hits on both bounds, raise and lower sequences, the clamp in both directions, timeouts (including the case where the timeout wins over the clamp), and a saturated count when the replica never returns. The replica model's delay falls as the step index rises. Settle lengths from 0 to 5 test the launch spacing after each step.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

    // depth of the return synchroniser; its latency is removed from the count
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_MEASURE,
        ST_DECIDE,
        ST_SETTLE,
        ST_FINISH
    } cal_state_e;

    typedef enum logic [1:0] {
        CLS_WINDOW,
        CLS_SLOW,
        CLS_FAST
    } cls_e;

    typedef struct packed {
        logic up;
        logic dn;
        logic hit_limit;
        logic expire;
        logic finish;
    } verdict_t;

    function automatic cls_e classify(int unsigned cnt, int unsigned lo, int unsigned hi);
        if (cnt > hi) return CLS_SLOW;
        if (cnt < lo) return CLS_FAST;
        return CLS_WINDOW;
    endfunction

    // round budget is checked before the step clamp
    function automatic verdict_t judge(cls_e c, logic spent, logic top, logic bottom);
        verdict_t v;
        v = '0;
        unique case (c)
            CLS_WINDOW: v.finish = 1'b1;
            CLS_SLOW: begin
                if (spent)    begin v.expire = 1'b1;    v.finish = 1'b1; end
                else if (top) begin v.hit_limit = 1'b1; v.finish = 1'b1; end
                else          v.up = 1'b1;
            end
            CLS_FAST: begin
                if (spent)       begin v.expire = 1'b1;    v.finish = 1'b1; end
                else if (bottom) begin v.hit_limit = 1'b1; v.finish = 1'b1; end
                else             v.dn = 1'b1;
            end
            default: v.finish = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pvs_sync.sv
module pvs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stage;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[0] <= 1'b0;
                else     stage[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/pvs_delay_meter.sv
module pvs_delay_meter #(
    parameter int CNT_W    = 8,
    parameter int SYNC_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             ret_sync,
    output logic             hit,
    output logic [CNT_W-1:0] result
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] LAT     = CNT_W'(SYNC_LAT);
    localparam logic [CNT_W-1:0] LAT_M1  = CNT_W'(SYNC_LAT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed;
    logic             seen;

    // a stale synchronised level from the previous round is masked
    assign armed  = (cnt_q >= LAT);
    assign seen   = armed && ret_sync;
    assign hit    = run && (seen || (cnt_q == CNT_MAX));
    assign result = seen ? (cnt_q - LAT_M1) : CNT_MAX;

    always_ff @(posedge clk) begin
        if (rst || clear)     cnt_q <= '0;
        else if (run && !hit) cnt_q <= cnt_q + 1'b1;
    end

    AST_RESULT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        hit |-> (result != '0)) else $error("zero count reported"); // R3
endmodule

// File: rtl/pvs_step_reg.sv
module pvs_step_reg #(
    parameter int STEP_W    = 4,
    parameter int STEP_MIN  = 0,
    parameter int STEP_MAX  = 15,
    parameter int STEP_INIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              dec,
    output logic [STEP_W-1:0] idx,
    output logic              at_top,
    output logic              at_bottom
);
    localparam logic [STEP_W-1:0] IDX_LO   = STEP_W'(STEP_MIN);
    localparam logic [STEP_W-1:0] IDX_HI   = STEP_W'(STEP_MAX);
    localparam logic [STEP_W-1:0] IDX_INIT = STEP_W'(STEP_INIT);

    logic [STEP_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst)                         idx_q <= IDX_INIT;
        else if (inc && idx_q != IDX_HI) idx_q <= idx_q + 1'b1;
        else if (dec && idx_q != IDX_LO) idx_q <= idx_q - 1'b1;
    end

    assign idx       = idx_q;
    assign at_top    = (idx_q == IDX_HI);
    assign at_bottom = (idx_q == IDX_LO);

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(idx_q) >= STEP_MIN) && (int'(idx_q) <= STEP_MAX)) else $error("step out of range"); // R9
endmodule

// File: rtl/periph_dvs_ctrl.sv
module periph_dvs_ctrl
    import pvs_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SETTLE_W  = 8,
    parameter int STEP_W    = 4,
    parameter int STEP_MIN  = 0,
    parameter int STEP_MAX  = 15,
    parameter int STEP_INIT = 8,
    parameter int MAX_ITER  = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pwrup_evt,
    input  logic                srexit_evt,
    input  logic [CNT_W-1:0]    win_hi,
    input  logic [CNT_W-1:0]    win_lo,
    input  logic [SETTLE_W-1:0] settle_len,
    input  logic                replica_ret,
    output logic                replica_launch,
    output logic                vreg_up,
    output logic                vreg_dn,
    output logic [STEP_W-1:0]   step_idx,
    output logic [CNT_W-1:0]    meas_count,
    output logic                cal_busy,
    output logic                cal_done,
    output logic                at_limit,
    output logic                cal_timeout
);
    localparam int               ITER_W    = $clog2(MAX_ITER + 1);
    localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER);

    cal_state_e          st_q, st_d;
    verdict_t            vd;
    logic                start;
    logic                ret_sync;
    logic                m_hit;
    logic [CNT_W-1:0]    m_result;
    logic                idx_top, idx_bottom;
    logic                up_q, dn_q, lim_q, tmo_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [ITER_W-1:0]   iter_q;
    logic [CNT_W-1:0]    meas_q;

    assign start = (st_q == ST_IDLE) && (pwrup_evt || srexit_evt);

    pvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (replica_ret),
        .q   (ret_sync)
    );

    pvs_delay_meter #(.CNT_W(CNT_W), .SYNC_LAT(SYNC_STAGES)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .clear    (st_q == ST_LAUNCH),
        .run      (st_q == ST_MEASURE),
        .ret_sync (ret_sync),
        .hit      (m_hit),
        .result   (m_result)
    );

    pvs_step_reg #(
        .STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX), .STEP_INIT(STEP_INIT)
    ) u_step (
        .clk       (clk),
        .rst       (rst),
        .inc       (vd.up),
        .dec       (vd.dn),
        .idx       (step_idx),
        .at_top    (idx_top),
        .at_bottom (idx_bottom)
    );

    always_comb begin
        vd = '0;
        if (st_q == ST_DECIDE)
            vd = judge(classify(32'(meas_q), 32'(win_lo), 32'(win_hi)),
                       iter_q == ITER_LAST, idx_top, idx_bottom);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start) st_d = ST_LAUNCH;
            ST_LAUNCH:  st_d = ST_MEASURE;
            ST_MEASURE: if (m_hit) st_d = ST_DECIDE;
            ST_DECIDE:  st_d = vd.finish ? ST_FINISH : ST_SETTLE;
            ST_SETTLE:  if (settle_q == '0) st_d = ST_LAUNCH;
            ST_FINISH:  st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            up_q     <= 1'b0;
            dn_q     <= 1'b0;
            lim_q    <= 1'b0;
            tmo_q    <= 1'b0;
            settle_q <= '0;
            iter_q   <= '0;
            meas_q   <= '0;
        end else begin
            st_q <= st_d;
            up_q <= vd.up;
            dn_q <= vd.dn;
            if (start) begin
                iter_q <= '0;
                lim_q  <= 1'b0;
                tmo_q  <= 1'b0;
            end else begin
                if (vd.up || vd.dn) iter_q <= iter_q + 1'b1;
                if (vd.hit_limit)   lim_q  <= 1'b1;
                if (vd.expire)      tmo_q  <= 1'b1;
            end
            if (vd.up || vd.dn)
                settle_q <= settle_len;
            else if (st_q == ST_SETTLE && settle_q != '0)
                settle_q <= settle_q - 1'b1;
            if (st_q == ST_MEASURE && m_hit)
                meas_q <= m_result;
        end
    end

    assign replica_launch = (st_q == ST_LAUNCH);
    assign vreg_up        = up_q;
    assign vreg_dn        = dn_q;
    assign meas_count     = meas_q;
    assign cal_busy       = (st_q != ST_IDLE);
    assign cal_done       = (st_q == ST_FINISH);
    assign at_limit       = lim_q;
    assign cal_timeout    = tmo_q;

    AST_UPDN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(vreg_up && vreg_dn)) else $error("raise and lower together"); // R7
    AST_LAUNCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        replica_launch |=> !replica_launch) else $error("launch wider than one cycle"); // R7
    AST_UP_RAISES_IDX: assert property (@(posedge clk) disable iff (rst)
        vreg_up |-> (step_idx == $past(step_idx) + 1'b1)) else $error("raise without index step"); // R4
    AST_DN_LOWERS_IDX: assert property (@(posedge clk) disable iff (rst)
        vreg_dn |-> (step_idx == $past(step_idx) - 1'b1)) else $error("lower without index step"); // R5
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cal_done |=> !cal_busy) else $error("busy after done"); // R11
    AST_IDLE_HOLDS_IDX: assert property (@(posedge clk) disable iff (rst)
        !cal_busy |=> $stable(step_idx)) else $error("index moved while idle"); // R12
    AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (vreg_up || vreg_dn) |-> cal_busy) else $error("step request outside calibration"); // R12
endmodule

// File: tb/periph_dvs_ctrl_test.sv
module periph_dvs_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 6;
    localparam int SETTLE_W   = 4;
    localparam int STEP_W     = 3;
    localparam int STEP_MIN   = 0;
    localparam int STEP_MAX   = 7;
    localparam int STEP_INIT  = 3;
    localparam int MAX_ITER   = 3;
    localparam int SAT        = (1 << CNT_W) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                pwrup_evt = 1'b0;
    logic                srexit_evt = 1'b0;
    logic [CNT_W-1:0]    win_hi = CNT_W'(30);
    logic [CNT_W-1:0]    win_lo = CNT_W'(20);
    logic [SETTLE_W-1:0] settle_len = '0;
    logic                replica_ret = 1'b0;
    logic                replica_launch, vreg_up, vreg_dn;
    logic [STEP_W-1:0]   step_idx;
    logic [CNT_W-1:0]    meas_count;
    logic                cal_busy, cal_done, at_limit, cal_timeout;

    periph_dvs_ctrl #(
        .CNT_W(CNT_W), .SETTLE_W(SETTLE_W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN),
        .STEP_MAX(STEP_MAX), .STEP_INIT(STEP_INIT), .MAX_ITER(MAX_ITER)
    ) uut (
        .clk(clk), .rst(rst), .pwrup_evt(pwrup_evt), .srexit_evt(srexit_evt),
        .win_hi(win_hi), .win_lo(win_lo), .settle_len(settle_len), .replica_ret(replica_ret),
        .replica_launch(replica_launch), .vreg_up(vreg_up), .vreg_dn(vreg_dn),
        .step_idx(step_idx), .meas_count(meas_count), .cal_busy(cal_busy), .cal_done(cal_done),
        .at_limit(at_limit), .cal_timeout(cal_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int settle_cur = 0;
    int model_idx = STEP_INIT;
    int rep_base = 40;
    int rep_slope = 5;
    bit rep_never = 1'b0;

    typedef struct {
        int n_up; int n_dn; int idx; int count; int lim; int tmo;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(string req, int actual, int expected, string what);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // replica delay falls as the supply step rises
    function automatic int rep_delay(int idx);
        int d;
        if (rep_never) return 1000;
        d = rep_base - rep_slope * idx;
        if (d < 1) d = 1;
        return d;
    endfunction

    // outcome computed from the requirements
    function automatic exp_t predict(int start_idx, int lo, int hi);
        exp_t e;
        int idx = start_idx;
        int iter = 0;
        int m;
        e.n_up = 0; e.n_dn = 0; e.lim = 0; e.tmo = 0; e.count = 0;
        while (1) begin
            m = rep_delay(idx);
            if (m > SAT) m = SAT;
            e.count = m;
            if (m > hi) begin
                if (iter == MAX_ITER) begin e.tmo = 1; break; end
                if (idx == STEP_MAX) begin e.lim = 1; break; end
                idx++; iter++; e.n_up++;
            end else if (m < lo) begin
                if (iter == MAX_ITER) begin e.tmo = 1; break; end
                if (idx == STEP_MIN) begin e.lim = 1; break; end
                idx--; iter++; e.n_dn++;
            end else break;
        end
        e.idx = idx;
        return e;
    endfunction

    // replica path: return rises D edges after launch is sampled, drops at next launch
    initial begin : replica
        int rem;
        bit armed;
        rem = 0;
        armed = 1'b0;
        forever begin
            @(negedge clk);
            if (replica_launch) begin
                replica_ret = 1'b0;
                rem = rep_delay(int'(step_idx)) - 1;
                armed = 1'b1;
            end else if (armed) begin
                if (rem == 0) begin
                    replica_ret = 1'b1;
                    armed = 1'b0;
                end else rem--;
            end
        end
    end

    initial begin : monitor
        int cyc;
        int last_step;
        int ups;
        int dns;
        exp_t e;
        cyc = 0; last_step = -1; ups = 0; dns = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (vreg_up) begin ups++; last_step = cyc; end
                if (vreg_dn) begin dns++; last_step = cyc; end
                if (replica_launch && last_step >= 0) begin
                    check("R8", cyc - last_step, settle_cur + 1, "launch spacing after step");
                    last_step = -1;
                end
                if (cal_done) begin
                    if (sb_q.size() == 0) begin
                        check("R12", 1, 0, "unexpected done");
                    end else begin
                        e = sb_q.pop_front();
                        check("R4", ups, e.n_up, "raise pulses");
                        check("R5", dns, e.n_dn, "lower pulses");
                        check("R3", int'(meas_count), e.count, "measured count");
                        check("R6", int'(step_idx), e.idx, "final step index");
                        check("R9", int'(at_limit), e.lim, "limit flag");
                        check("R10", int'(cal_timeout), e.tmo, "timeout flag");
                    end
                    ups = 0; dns = 0; last_step = -1;
                end
            end
        end
    end

    task automatic run_cal(int base, int slope, bit never, int settle, bit use_srx, bit poke);
        exp_t e;
        @(negedge clk);
        rep_base = base; rep_slope = slope; rep_never = never;
        settle_len = SETTLE_W'(settle); settle_cur = settle;
        e = predict(model_idx, int'(win_lo), int'(win_hi));
        model_idx = e.idx;
        sb_q.push_back(e);
        if (use_srx) srexit_evt = 1'b1; else pwrup_evt = 1'b1;
        @(negedge clk);
        pwrup_evt = 1'b0; srexit_evt = 1'b0;
        check("R2", int'(replica_launch), 1, "launch after event");
        check("R2", int'(cal_busy), 1, "busy after event");
        check("R11", int'(at_limit), 0, "limit flag cleared at start");
        check("R11", int'(cal_timeout), 0, "timeout flag cleared at start");
        if (poke) begin
            repeat (6) @(negedge clk);
            pwrup_evt = 1'b1; srexit_evt = 1'b1;
            @(negedge clk);
            pwrup_evt = 1'b0; srexit_evt = 1'b0;
        end
        while (!cal_done) @(negedge clk);
        @(negedge clk);
        check("R11", int'(cal_busy), 0, "busy after done");
        repeat (4) begin
            @(negedge clk);
            check("R12", int'(cal_busy), 0, "no restart from event during busy");
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R2 watchdog: actual no completion expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", int'(step_idx), STEP_INIT, "reset step index");
        check("R1", int'(cal_busy), 0, "reset busy");
        check("R1", int'(replica_launch), 0, "reset launch");
        check("R1", int'(vreg_up) + int'(vreg_dn), 0, "reset step requests");
        check("R1", int'(cal_done) + int'(at_limit) + int'(cal_timeout), 0, "reset done and flags");
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(cal_busy), 0, "busy after reset release");
        check("R1", int'(step_idx), STEP_INIT, "index after reset release");

        run_cal(40, 5, 0, 5, 0, 0);   // R6 in window at once, count 25
        run_cal(60, 5, 0, 5, 1, 1);   // R4 three raises, lands on upper bound 30
        run_cal(10, 1, 0, 3, 0, 0);   // R5 lowers then R10 timeout
        run_cal(5, 1, 0, 2, 1, 0);    // R10 timeout wins when clamp is also near
        run_cal(5, 1, 0, 2, 0, 0);    // R9 lower clamp
        run_cal(0, 0, 1, 1, 0, 0);    // R3 saturation, raises, timeout
        run_cal(0, 0, 1, 4, 1, 0);    // R10 again from step 3
        run_cal(0, 0, 1, 4, 0, 0);    // R9 upper clamp after one raise
        run_cal(30, 2, 0, 0, 1, 1);   // R5 lowers with zero settle, lands on lower bound 20

        // R12 idle hold while inputs move
        rep_base = 2; rep_slope = 0;
        win_lo = CNT_W'(40); win_hi = CNT_W'(50);
        repeat (10) @(negedge clk);
        check("R12", int'(step_idx), model_idx, "index held while idle");
        check("R12", int'(cal_busy), 0, "no calibration without event");
        check("R2", sb_q.size(), 0, "all calibrations completed");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule